// File: doc/BRIEF.md
# Sequential Multiplier with Low and High Product Forms

This block multiplies two W-bit operands (W = 32 by default) over a fixed number of clock cycles. It returns one W-bit word: either the low half of the product or one of three forms of the high half. The three high forms treat the operands as unsigned by unsigned, signed by unsigned, or signed by signed. The form is chosen by a 6-bit primary opcode together with a 6-bit extended opcode. These are the same fields an instruction decoder already holds, so the block can sit behind an execution stage that issues a multiply and waits for the result.

A separate immediate form uses a sign-extended IMM_W-bit constant in place of the second operand and always returns the low product. Both the low and the unsigned high accumulations are built in a single loop of W iterations. The low half shifts left and the high half shifts right. The signed high forms come from the unsigned high result through one extra correction cycle, which subtracts operands. A one-cycle `start` launches an operation, `busy` covers the work, and a one-cycle `done` marks a valid `result`.

Top module: `seqmul_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: An operation is accepted only when the block is idle, `start` is 1, and the opcodes are one of these five pairs. Primary 0x3A with extended 0x27 selects the low product. Primary 0x3A with extended 0x07 selects the unsigned×unsigned high product. Primary 0x3A with extended 0x17 selects the signed-A × unsigned-B high product. Primary 0x3A with extended 0x1F selects the signed×signed high product. Primary 0x24 selects the immediate form, and its extended opcode is not looked at.
- R3: The low form returns bits W-1..0 of `srcA`×`srcB`.
- R4: The unsigned high form returns bits 2W-1..W of the product, with both operands read as unsigned.
- R5: The signed×unsigned high form returns bits 2W-1..W of the product, with `srcA` read as two's complement and `srcB` as unsigned.
- R6: The signed×signed high form returns bits 2W-1..W of the product, with both operands read as two's complement.
- R7: The immediate form returns the low W bits of `srcA` times `imm` sign-extended to W bits. `srcB` has no effect on it.
- R8: `busy` is 1 for exactly W+1 cycles after the accepting clock edge. `done` is 1 in the cycle after that, W+2 edges after acceptance.
- R9: `done` lasts one cycle. `result` changes only when `done` rises and holds its value until the next completion.
- R10: While an operation runs, `start` and any change on the opcode, operand or immediate inputs have no effect on that operation's result or timing.
- R11: `start` with any other opcode pair is ignored. `busy` and `done` stay 0 and `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch request, sampled when idle |
| primOp | input | 6 | Primary opcode (0x3A register form, 0x24 immediate form) |
| extOp | input | 6 | Extended opcode selecting the product form |
| srcA | input | W | First operand (multiplicand) |
| srcB | input | W | Second operand for register forms |
| imm | input | IMM_W | Immediate operand, sign-extended |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | W | Selected product word |

## Verification
The operands are captured once, so a corrupted accumulator, a shift in the wrong direction or a miscounted loop shows up only in `result`, in the single cycle where `done` rises W+2 edges after acceptance. A wrong high or low bit is visible only for operands that reach it. For this reason the small configuration is swept over every operand pair in every form, and the full-width instance is driven with sign-boundary and all-ones values. A wrong iteration count or a stuck state moves the `done` edge, so latency is compared on every operation. A mode register that loses its value shows up as a correctly sized but wrong-signed high word.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  localparam logic [5:0] OP_REG  = 6'h3A;
  localparam logic [5:0] OP_IMM  = 6'h24;
  localparam logic [5:0] EXT_LOW = 6'h27;
  localparam logic [5:0] EXT_UU  = 6'h07;
  localparam logic [5:0] EXT_SU  = 6'h17;
  localparam logic [5:0] EXT_SS  = 6'h1F;

  typedef enum logic [1:0] {
    MD_LOW   = 2'd0,
    MD_HI_UU = 2'd1,
    MD_HI_SU = 2'd2,
    MD_HI_SS = 2'd3
  } mulMode_e;

  typedef struct packed {
    logic     valid;
    logic     useImm;
    mulMode_e mode;
  } opDecode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     step;
    logic     fix;
    logic     useImm;
    mulMode_e mode;
  } mulCtrl_t;

  function automatic opDecode_t decodeOp(input logic [5:0] prim, input logic [5:0] ext);
    opDecode_t d;
    d = '{valid: 1'b0, useImm: 1'b0, mode: MD_LOW};
    if (prim == OP_IMM) begin
      d.valid  = 1'b1;
      d.useImm = 1'b1;
    end else if (prim == OP_REG) begin
      case (ext)
        EXT_LOW: begin d.valid = 1'b1; d.mode = MD_LOW;   end
        EXT_UU:  begin d.valid = 1'b1; d.mode = MD_HI_UU; end
        EXT_SU:  begin d.valid = 1'b1; d.mode = MD_HI_SU; end
        EXT_SS:  begin d.valid = 1'b1; d.mode = MD_HI_SS; end
        default: d.valid = 1'b0;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [5:0] primOp,
  input  logic [5:0] extOp,
  output mulCtrl_t   ctl,
  output logic       busy,
  output logic       done
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX, S_DONE} ctlState_e;

  ctlState_e stateQ;
  logic [CW-1:0] iterLeft;
  opDecode_t dec;

  always_comb begin
    dec        = decodeOp(primOp, extOp);
    ctl.load   = (stateQ == S_IDLE) && start && dec.valid;
    ctl.step   = (stateQ == S_RUN);
    ctl.fix    = (stateQ == S_FIX);
    ctl.useImm = dec.useImm;
    ctl.mode   = dec.mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ   <= S_IDLE;
      iterLeft <= '0;
    end else begin
      case (stateQ)
        S_IDLE: if (ctl.load) begin
          stateQ   <= S_RUN;
          iterLeft <= CW'(W - 1);
        end
        S_RUN: begin
          if (iterLeft == '0) stateQ <= S_FIX;
          else iterLeft <= iterLeft - 1'b1;
        end
        S_FIX:   stateQ <= S_DONE;
        S_DONE:  stateQ <= S_IDLE;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign busy = (stateQ == S_RUN) || (stateQ == S_FIX);
  assign done = (stateQ == S_DONE);

endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath
  import seqmul_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mulCtrl_t         ctl,
  input  logic [W-1:0]     srcA,
  input  logic [W-1:0]     srcB,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     result
);

  logic [W-1:0] immExt;
  logic [W-1:0] bSel;

  generate
    if (IMM_W < W) begin : gSext
      assign immExt = {{(W - IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : gTrunc
      assign immExt = imm[W-1:0];
    end
  endgenerate

  assign bSel = ctl.useImm ? immExt : srcB;

  logic [W-1:0] mcand;      // operand A, held
  logic [W-1:0] origMul;    // operand B, held for correction
  logic [W-1:0] mulLeft;    // multiplier copy scanned from MSB
  logic [W-1:0] mulRight;   // multiplier copy scanned from LSB
  logic [W-1:0] lowAcc;
  logic [W-1:0] hiAcc;
  mulMode_e     modeQ;

  logic [W-1:0] lowNext;
  logic [W:0]   hiSum;
  logic [W-1:0] corrSU;
  logic [W-1:0] corrSS;
  logic [W-1:0] fixVal;

  always_comb begin
    lowNext = (lowAcc << 1) + (mulLeft[W-1] ? mcand : '0);
    hiSum   = {1'b0, hiAcc} + {1'b0, (mulRight[0] ? mcand : '0)};
    corrSU  = hiAcc - (mcand[W-1] ? origMul : '0);
    corrSS  = corrSU - (origMul[W-1] ? mcand : '0);
    case (modeQ)
      MD_LOW:   fixVal = lowAcc;
      MD_HI_UU: fixVal = hiAcc;
      MD_HI_SU: fixVal = corrSU;
      default:  fixVal = corrSS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand    <= '0;
      origMul  <= '0;
      mulLeft  <= '0;
      mulRight <= '0;
      lowAcc   <= '0;
      hiAcc    <= '0;
      modeQ    <= MD_LOW;
      result   <= '0;
    end else begin
      if (ctl.load) begin
        mcand    <= srcA;
        origMul  <= bSel;
        mulLeft  <= bSel;
        mulRight <= bSel;
        lowAcc   <= '0;
        hiAcc    <= '0;
        modeQ    <= ctl.mode;
      end else if (ctl.step) begin
        lowAcc  <= lowNext;
        mulLeft <= mulLeft << 1;
        // carry, sum and remaining multiplier bits shift right as one word
        {hiAcc, mulRight} <= {hiSum, mulRight[W-1:1]};
      end
      if (ctl.fix) result <= fixVal;
    end
  end

endmodule

// File: rtl/seqmul_unit.sv
module seqmul_unit
  import seqmul_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [5:0]       primOp,
  input  logic [5:0]       extOp,
  input  logic [W-1:0]     srcA,
  input  logic [W-1:0]     srcB,
  input  logic [IMM_W-1:0] imm,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     result
);

  mulCtrl_t ctl;

  seqmul_ctrl #(.W(W)) uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .primOp (primOp),
    .extOp  (extOp),
    .ctl    (ctl),
    .busy   (busy),
    .done   (done)
  );

  seqmul_datapath #(.W(W), .IMM_W(IMM_W)) uPath (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .srcA   (srcA),
    .srcB   (srcB),
    .imm    (imm),
    .result (result)
  );

endmodule

// File: rtl/seqmul_unit_chk.sv
module seqmul_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [5:0]   primOp,
  input logic [5:0]   extOp,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);

  logic validEnc;
  assign validEnc = (primOp == 6'h24) ||
                    ((primOp == 6'h3A) &&
                     (extOp == 6'h27 || extOp == 6'h07 || extOp == 6'h17 || extOp == 6'h1F));

  logic [15:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rst_n) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 16'd1;
    else busyRun <= '0;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busyRun == 16'(W + 1));

  // R10
  busy_continues_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && start && validEnc) |=> busy);

  // R11
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !(start && validEnc)) |=> (!busy && !done));

endmodule

bind seqmul_unit seqmul_unit_chk #(.W(W)) uChk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .primOp (primOp),
  .extOp  (extOp),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/seqmul_unit_test.sv
`timescale 1ns/1ps
module seqmul_unit_test;

  localparam int WW = 32;
  localparam int WI = 16;
  localparam int SW = 5;
  localparam int SI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;

  // wide instance
  logic          wStart = 1'b0;
  logic [5:0]    wPrim = '0, wExt = '0;
  logic [WW-1:0] wA = '0, wB = '0;
  logic [WI-1:0] wImm = '0;
  logic          wBusy, wDone;
  logic [WW-1:0] wRes;

  seqmul_unit #(.W(WW), .IMM_W(WI)) uut (
    .clk(clk), .rst_n(rst_n), .start(wStart), .primOp(wPrim), .extOp(wExt),
    .srcA(wA), .srcB(wB), .imm(wImm), .busy(wBusy), .done(wDone), .result(wRes)
  );

  // small instance for exhaustive sweeps
  logic          sStart = 1'b0;
  logic [5:0]    sPrim = '0, sExt = '0;
  logic [SW-1:0] sA = '0, sB = '0;
  logic [SI-1:0] sImm = '0;
  logic          sBusy, sDone;
  logic [SW-1:0] sRes;

  seqmul_unit #(.W(SW), .IMM_W(SI)) uutSmall (
    .clk(clk), .rst_n(rst_n), .start(sStart), .primOp(sPrim), .extOp(sExt),
    .srcA(sA), .srcB(sB), .imm(sImm), .busy(sBusy), .done(sDone), .result(sRes)
  );

  function automatic logic [5:0] extOf(input int k);
    case (k)
      0: return 6'h27;
      1: return 6'h07;
      2: return 6'h17;
      default: return 6'h1F;
    endcase
  endfunction

  function automatic string tagOf(input int k);
    case (k)
      0: return "R3 low";
      1: return "R4 high uu";
      2: return "R5 high su";
      default: return "R6 high ss";
    endcase
  endfunction

  // k: 0 low, 1 uu high, 2 su high, 3 ss high
  function automatic logic [63:0] refMul(input logic [63:0] a, input logic [63:0] b,
                                         input int w, input int k);
    logic [63:0] mask, ea, eb, p;
    mask = (64'd1 << w) - 64'd1;
    ea = a & mask;
    eb = b & mask;
    if (k >= 2 && ea[w-1]) ea = ea | ~mask;
    if (k == 3 && eb[w-1]) eb = eb | ~mask;
    p = ea * eb;
    return (k == 0) ? (p & mask) : ((p >> w) & mask);
  endfunction

  function automatic logic [63:0] sext(input logic [63:0] v, input int w);
    logic [63:0] mask, e;
    mask = (64'd1 << w) - 64'd1;
    e = v & mask;
    if (e[w-1]) e = e | ~mask;
    return e;
  endfunction

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0002;
      3: return 32'h0000_0003;
      4: return 32'h7FFF_FFFF;
      5: return 32'h8000_0000;
      6: return 32'h8000_0001;
      7: return 32'hFFFF_FFFF;
      8: return 32'hFFFF_FFFE;
      9: return 32'h1234_5678;
      10: return 32'hDEAD_BEEF;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runWide(input logic [5:0] prim, input logic [5:0] ext, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im, input logic [31:0] exp,
                         input string tag, input bit disturb);
    int cyc;
    bit seen;
    @(negedge clk);
    wPrim = prim; wExt = ext; wA = a; wB = b; wImm = im; wStart = 1'b1;
    cyc = 0; seen = 0;
    while (!seen && cyc < WW + 20) begin
      @(negedge clk);
      wStart = 1'b0;
      cyc++;
      if (disturb && cyc == 3) begin
        wA = ~a; wB = b + 32'd1; wImm = ~im; wExt = 6'h1F; wStart = 1'b1;
      end
      if (wDone) seen = 1;
    end
    wStart = 1'b0;
    check(seen && wRes == exp, tag, wRes, exp);
    check(cyc == WW + 2, "R8 latency wide", cyc, WW + 2);
  endtask

  task automatic runSmall(input logic [5:0] prim, input logic [5:0] ext, input logic [SW-1:0] a,
                          input logic [SW-1:0] b, input logic [SI-1:0] im, input logic [SW-1:0] exp,
                          input string tag);
    int cyc;
    bit seen;
    @(negedge clk);
    sPrim = prim; sExt = ext; sA = a; sB = b; sImm = im; sStart = 1'b1;
    cyc = 0; seen = 0;
    while (!seen && cyc < SW + 20) begin
      @(negedge clk);
      sStart = 1'b0;
      cyc++;
      if (sDone) seen = 1;
    end
    check(seen && sRes == exp, tag, sRes, exp);
    check(cyc == SW + 2, "R8 latency small", cyc, SW + 2);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R8 watchdog expired: actual hung expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] held;
    bit sawAct;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!wBusy && !wDone && wRes == '0, "R1 reset wide", {wBusy, wDone, wRes}, 0);
    check(!sBusy && !sDone && sRes == '0, "R1 reset small", {sBusy, sDone, sRes}, 0);

    // R11 unsupported encodings ignored
    for (int t = 0; t < 3; t++) begin
      held = wRes;
      @(negedge clk);
      wPrim = (t == 0) ? 6'h3A : ((t == 1) ? 6'h00 : 6'h3B);
      wExt  = (t == 0) ? 6'h25 : 6'h27;
      wA = 32'h5; wB = 32'h7; wStart = 1'b1;
      sawAct = 0;
      for (int c = 0; c < WW + 6; c++) begin
        @(negedge clk);
        wStart = 1'b0;
        if (wBusy || wDone) sawAct = 1;
      end
      check(!sawAct && wRes == held, "R11 rejected encoding", {sawAct, wRes}, {1'b0, held});
    end

    // R2..R6 wide corners in all four forms
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int k = 0; k < 4; k++)
          runWide(6'h3A, extOf(k), corner(i), corner(j), 16'h0,
                  32'(refMul(64'(corner(i)), 64'(corner(j)), WW, k)), tagOf(k), 1'b0);

    // R7 immediate form, srcB is junk and must not matter
    for (int i = 0; i < 12; i++)
      for (int m = 0; m < 5; m++) begin
        logic [15:0] im;
        im = (m == 0) ? 16'h8000 : (m == 1) ? 16'h7FFF : (m == 2) ? 16'hFFFF :
             (m == 3) ? 16'h0001 : 16'hA5C3;
        runWide(6'h24, 6'h3F, corner(i), ~corner(i), im,
                32'(refMul(64'(corner(i)), sext(64'(im), WI), WW, 0)), "R7 immediate wide", 1'b0);
      end

    // R10 disturbance while running
    runWide(6'h3A, 6'h27, 32'h1234_5678, 32'h9ABC_DEF0, 16'h0,
            32'(refMul(64'h1234_5678, 64'h9ABC_DEF0, WW, 0)), "R10 inputs changed mid-run", 1'b1);
    runWide(6'h3A, 6'h07, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0,
            32'(refMul(64'hFFFF_FFFF, 64'h8000_0000, WW, 1)), "R10 inputs changed mid-run", 1'b1);

    // R9 done is a single pulse, result held
    held = wRes;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(!wDone && wRes == held, "R9 done pulse and hold", {wDone, wRes}, {1'b0, held});
    end

    // exhaustive sweep of the small configuration
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        for (int k = 0; k < 4; k++)
          runSmall(6'h3A, extOf(k), SW'(a), SW'(b), '0,
                   SW'(refMul(64'(a), 64'(b), SW, k)), tagOf(k));

    for (int a = 0; a < 32; a++)
      for (int m = 0; m < 8; m++)
        runSmall(6'h24, 6'h00, SW'(a), SW'(a ^ 21), SI'(m),
                 SW'(refMul(64'(a), sext(64'(m), SI), SW, 0)), "R7 immediate small");

    finishRun();
  end

endmodule